// File: doc/BRIEF.md
# Receive Sample Slicer with Interface Gain Selection

This block turns a wide signed I/Q receive stream into 16-bit words for a narrower data port. It multiplies each sample by a power of two, one step for every 6 dB of interface gain. Positive gain is a left shift that saturates at the 16-bit limits. Negative gain is an arithmetic right shift that drops low-order bits. A flag marks every output sample in which either lane had to be clipped.

The gain comes from one of two sources. In manual mode the host supplies a code, and the block clamps it to the range allowed for the selected bandwidth. In automatic mode the block adds up I²+Q² over a window of 2^N valid samples. At the end of each window it picks the largest legal gain for which the mean power, raised by a crest-factor margin of 32 (about 15 dB), still stays below output full scale. The gain code that belongs to each output sample is presented next to it, so the host can refer measured power back to the input.

Top module: `rx_slicer`

## Requirements
- R1: Gain codes are 4-bit two's complement, and one unit is 6 dB. A negative code g applies an arithmetic right shift by |g| to each lane. With g = -s, the output equals input bits D(15+s)..D(s) whenever that value fits in 16 bits.
- R2: A code g >= 0 multiplies each lane by 2^g. Any result above 32767 or below -32768 saturates to that limit. This saturation also applies at g = 0.
- R3: outSat is 1 on an output cycle with outValid=1 in which the I lane or the Q lane was saturated. In every other cycle it is 0.
- R4: With manualMode=1, the applied code is manualGain clamped to [-6,+3] when bwWide=0 (narrowband) and to [-6,0] when bwWide=1 (wideband).
- R5: With manualMode=0, the block forms the sum S of I²+Q² over 2^N valid samples (N=WIN_LOG2, default 4). It then picks the largest legal g with S·2^(2g+5) < 2^(30+N). If no legal g satisfies this, it picks -6. The legal range is [-6,+3] for narrowband and [-6,0] for wideband, sampled when the window closes.
- R6: The automatic code changes only when a window closes. Cycles with inValid=0 do not count toward a window. The sample that closes a window still uses the old code, and the new code applies from the next sample.
- R7: outGain shows the code that was applied to the sample currently on outI/outQ.
- R8: outValid repeats inValid two clock cycles later.
- R9: After reset, all outputs are 0, the automatic code is 0 and the window count is empty.
- R10: In automatic mode, the stored code is clamped to the range of the bandwidth currently selected before it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | 23 | Signed in-phase input sample |
| inQ | input | 23 | Signed quadrature input sample |
| bwWide | input | 1 | 0 = narrowband range, 1 = wideband range |
| manualMode | input | 1 | 1 = host gain code, 0 = automatic |
| manualGain | input | 4 | Host gain code, two's complement, 6 dB units |
| outValid | output | 1 | Output sample strobe |
| outI | output | 16 | Scaled in-phase sample |
| outQ | output | 16 | Scaled quadrature sample |
| outGain | output | 4 | Gain code applied to the present output sample |
| outSat | output | 1 | Saturation on either lane of the present sample |

## Verification
The bench sweeps every manual code from -8 to +7 in both bandwidth modes against near-full-scale, tiny and negative samples. A wrong clamp would let +5 or -8 through, and a wrong shift direction or missing saturation would wrap large values instead of pinning them. In automatic mode the bench feeds windows at amplitudes chosen to land on +3, 0, -3 and -6, with idle cycles mixed in. A design that counts idle cycles, or that switches gain on the closing sample instead of the next one, mislabels samples around each boundary. A switch to wideband while the stored code is +3 shows whether the applied code is clamped at once.

// File: rtl/rx_slicer_pkg.sv
package rx_slicer_pkg;
  parameter int GAIN_W = 4;

  typedef struct packed {
    logic                     take;    // sample accepted this cycle
    logic                     winEnd;  // window closes on this sample
    logic signed [GAIN_W-1:0] gain;    // code applied to this sample
  } slice_ctrl_t;
endpackage

// File: rtl/rx_slicer_ctrl.sv
module rx_slicer_ctrl
  import rx_slicer_pkg::*;
#(
  parameter int IN_W        = 23,
  parameter int OUT_W       = 16,
  parameter int WIN_LOG2    = 4,
  parameter int MARGIN_LOG2 = 5,
  parameter int MIN_GAIN    = -6,
  parameter int MAX_NB      = 3,
  parameter int MAX_WB      = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [IN_W-1:0]   inI,
  input  logic signed [IN_W-1:0]   inQ,
  input  logic                     bwWide,
  input  logic                     manualMode,
  input  logic signed [GAIN_W-1:0] manualGain,
  output slice_ctrl_t              ctrl
);
  localparam int SQ_W  = 2 * IN_W;
  localparam int SUM_W = SQ_W + WIN_LOG2 + 1;
  localparam int NSTEP = MAX_NB - MIN_GAIN + 1;
  localparam logic signed [GAIN_W-1:0] LO = GAIN_W'(MIN_GAIN);

  logic signed [SQ_W-1:0]   iSq, qSq;
  logic [SUM_W-1:0]         acc, sumNext;
  logic [WIN_LOG2-1:0]      cnt;
  logic                     winEnd;
  logic signed [GAIN_W-1:0] autoGain, pick, gMax, rawGain;
  logic [NSTEP-1:0]         legal;
  logic signed [GAIN_W-1:0] stepCode [NSTEP];

  assign iSq     = inI * inI;
  assign qSq     = inQ * inQ;
  assign sumNext = acc + SUM_W'($unsigned(iSq)) + SUM_W'($unsigned(qSq));
  assign winEnd  = inValid && (cnt == '1);
  assign gMax    = bwWide ? GAIN_W'(MAX_WB) : GAIN_W'(MAX_NB);

  // one candidate per gain step: the power fits if nothing survives the shift
  for (genvar k = 0; k < NSTEP; k++) begin : g_step
    localparam int SH = 2 * (OUT_W - 1) - MARGIN_LOG2 + WIN_LOG2 - 2 * (MIN_GAIN + k);
    assign stepCode[k] = GAIN_W'(MIN_GAIN + k);
    assign legal[k]    = ((sumNext >> SH) == '0) && (stepCode[k] <= gMax);
  end

  always_comb begin
    pick = LO;
    for (int k = 0; k < NSTEP; k++)
      if (legal[k]) pick = stepCode[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      cnt      <= '0;
      autoGain <= '0;
    end else if (winEnd) begin
      acc      <= '0;
      cnt      <= '0;
      autoGain <= pick;
    end else if (inValid) begin
      acc <= sumNext;
      cnt <= cnt + 1'b1;
    end
  end

  assign rawGain = manualMode ? manualGain : autoGain;

  always_comb begin
    ctrl.take   = inValid;
    ctrl.winEnd = winEnd;
    if (rawGain < LO)        ctrl.gain = LO;
    else if (rawGain > gMax) ctrl.gain = gMax;
    else                     ctrl.gain = rawGain;
  end
endmodule

// File: rtl/rx_slicer_dp.sv
module rx_slicer_dp
  import rx_slicer_pkg::*;
#(
  parameter int IN_W  = 23,
  parameter int OUT_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slice_ctrl_t              ctrl,
  input  logic signed [IN_W-1:0]   inI,
  input  logic signed [IN_W-1:0]   inQ,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ,
  output logic signed [GAIN_W-1:0] outGain,
  output logic                     outSat
);
  localparam int WIDE_W = IN_W + 2 ** (GAIN_W - 1);
  localparam logic signed [WIDE_W-1:0] SAT_HI = WIDE_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] SAT_LO = -SAT_HI - 1;

  logic                     s1Valid;
  logic signed [GAIN_W-1:0] s1Gain;
  logic [GAIN_W-1:0]        negGain;
  logic signed [IN_W-1:0]   s1Smp  [2];
  logic signed [OUT_W-1:0]  scaled [2];
  logic [1:0]               clip;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Gain   <= '0;
      s1Smp[0] <= '0;
      s1Smp[1] <= '0;
    end else begin
      s1Valid  <= ctrl.take;
      s1Gain   <= ctrl.gain;
      s1Smp[0] <= inI;
      s1Smp[1] <= inQ;
    end
  end

  assign negGain = '0 - s1Gain;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic signed [WIDE_W-1:0] ext, shifted;
    assign ext     = WIDE_W'(s1Smp[l]);
    assign shifted = s1Gain[GAIN_W-1] ? (ext >>> negGain) : (ext <<< s1Gain);
    assign clip[l] = (shifted > SAT_HI) || (shifted < SAT_LO);
    assign scaled[l] = (shifted > SAT_HI) ? SAT_HI[OUT_W-1:0] :
                       (shifted < SAT_LO) ? SAT_LO[OUT_W-1:0] : shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outI     <= '0;
      outQ     <= '0;
      outGain  <= '0;
      outSat   <= 1'b0;
    end else begin
      outValid <= s1Valid;
      outI     <= scaled[0];
      outQ     <= scaled[1];
      outGain  <= s1Gain;
      outSat   <= s1Valid && (clip != 2'b00);
    end
  end
endmodule

// File: rtl/rx_slicer.sv
module rx_slicer
  import rx_slicer_pkg::*;
#(
  parameter int IN_W     = 23,
  parameter int OUT_W    = 16,
  parameter int WIN_LOG2 = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [IN_W-1:0]   inI,
  input  logic signed [IN_W-1:0]   inQ,
  input  logic                     bwWide,
  input  logic                     manualMode,
  input  logic signed [GAIN_W-1:0] manualGain,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ,
  output logic signed [GAIN_W-1:0] outGain,
  output logic                     outSat
);
  slice_ctrl_t ctrlBus;

  rx_slicer_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .WIN_LOG2(WIN_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .bwWide(bwWide), .manualMode(manualMode), .manualGain(manualGain),
    .ctrl(ctrlBus)
  );

  rx_slicer_dp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .inI(inI), .inQ(inQ),
    .outValid(outValid), .outI(outI), .outQ(outQ),
    .outGain(outGain), .outSat(outSat)
  );
endmodule

// File: rtl/rx_slicer_chk.sv
module rx_slicer_chk
  import rx_slicer_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     bwWide,
  input logic                     manualMode,
  input logic                     outValid,
  input logic signed [OUT_W-1:0]  outI,
  input logic signed [OUT_W-1:0]  outQ,
  input logic signed [GAIN_W-1:0] outGain,
  input logic                     outSat,
  input slice_ctrl_t              ctrlBus
);
  localparam logic signed [OUT_W-1:0] TOP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] BOT = {1'b1, {(OUT_W-1){1'b0}}};

  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (!rstN)           since <= '0;
    else if (since != 2'd3) since <= since + 1'b1;
  end

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (since >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R3
  sat_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !outSat);

  // R2
  sat_at_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSat |-> (outI == TOP || outI == BOT || outQ == TOP || outQ == BOT));

  // R4
  gain_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.gain >= -4'sd6) && (ctrlBus.gain <= (bwWide ? 4'sd0 : 4'sd3)));

  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((since >= 2'd1) && !manualMode && !$past(manualMode) && $stable(bwWide)
      && !$stable(ctrlBus.gain)) |-> $past(ctrlBus.winEnd));

  // R7
  gain_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (since >= 2'd2) |-> (outGain == $past(ctrlBus.gain, 2)));
endmodule

bind rx_slicer rx_slicer_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .bwWide(bwWide),
  .manualMode(manualMode), .outValid(outValid), .outI(outI), .outQ(outQ),
  .outGain(outGain), .outSat(outSat), .ctrlBus(ctrlBus)
);

// File: tb/rx_slicer_tb.sv
`timescale 1ns/1ps
module rx_slicer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [22:0] inI = '0, inQ = '0;
  logic bwWide = 1'b0, manualMode = 1'b1;
  logic signed [3:0] manualGain = '0;
  logic outValid, outSat;
  logic signed [15:0] outI, outQ;
  logic signed [3:0] outGain;

  always #10 clk = ~clk;  // 50 MHz

  rx_slicer u_dut (.*);

  typedef struct {bit v; bit s; int i; int q; int g; string tag;} exp_t;
  exp_t expQ[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int mgInt = 0;
  int autoModel = 0;
  longint accModel = 0;
  int cntModel = 0;

  function automatic int clampG(int c, bit wide);
    int hi = wide ? 0 : 3;
    if (c < -6) return -6;
    if (c > hi) return hi;
    return c;
  endfunction

  function automatic longint scaleS(int x, int g, output bit clipped);
    longint v = x;
    if (g >= 0) v = v * (64'sd1 <<< g);
    else        v = v >>> (-g);
    clipped = 1'b0;
    if (v > 32767)  begin v = 32767;  clipped = 1'b1; end
    if (v < -32768) begin v = -32768; clipped = 1'b1; end
    return v;
  endfunction

  // R5: largest legal g with S*2^(2g+5) < 2^34, else -6
  function automatic int pickAuto(longint s, bit wide);
    for (int g = (wide ? 0 : 3); g >= -6; g--)
      if (s < (64'sd1 <<< (29 - 2 * g))) return g;
    return -6;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic step(bit v, int i, int q, string tag);
    exp_t e;
    bit ci, cq;
    int g;
    inValid = v; inI = 23'(i); inQ = 23'(q);
    manualGain = 4'(mgInt);
    g = clampG(manualMode ? mgInt : autoModel, bwWide);
    e.v = v; e.g = g; e.tag = tag;
    e.i = int'(scaleS(i, g, ci));
    e.q = int'(scaleS(q, g, cq));
    e.s = v && (ci || cq);
    expQ.push_back(e);
    @(posedge clk);
    if (v) begin
      accModel += longint'(i) * i + longint'(q) * q;
      cntModel++;
      if (cntModel == 16) begin
        autoModel = pickAuto(accModel, bwWide);
        accModel = 0; cntModel = 0;
      end
    end
    @(negedge clk);
    e = expQ.pop_front();
    chk(outValid == e.v, "R8", "outValid", outValid, e.v);
    chk(outSat == e.s, {e.tag, "/R3"}, "outSat", outSat, e.s);
    chk(int'(outGain) == e.g, {e.tag, "/R7"}, "outGain", outGain, e.g);
    if (e.v) begin
      chk(int'(outI) == e.i, e.tag, "outI", outI, e.i);
      chk(int'(outQ) == e.q, e.tag, "outQ", outQ, e.q);
    end
  endtask

  task automatic window(int amp, int gaps, string tag);
    for (int n = 0; n < 16; n++) begin
      step(1'b1, amp - n, -amp + 2 * n, tag);
      if (n < gaps) step(1'b0, 7, 7, tag);
    end
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int vals[10] = '{1, -1, 1000, -1000, 40000, -40000, 4194303, -4194304, 12345, -32768};
    repeat (3) @(negedge clk);
    // R9: outputs held at zero in reset
    chk(outValid == 0 && outSat == 0, "R9", "reset flags", {outValid, outSat}, 0);
    chk(outI == 0 && outQ == 0, "R9", "reset data", outI, 0);
    chk(outGain == 0, "R9", "reset gain", outGain, 0);
    rstN = 1'b1;
    expQ.push_back('{0, 0, 0, 0, 0, "R9"});
    // R1 R2 R4: manual sweep in both bandwidths
    manualMode = 1'b1;
    for (int w = 0; w < 2; w++) begin
      bwWide = w[0];
      for (int c = -8; c < 8; c++) begin
        mgInt = c;
        foreach (vals[k]) step(1'b1, vals[k], -(vals[k] / 3), "R1/R2/R4");
        step(1'b0, 0, 0, "R8");
      end
    end
    // R5 R6: automatic mode, narrowband, with idle gaps
    manualMode = 1'b0; bwWide = 1'b0; mgInt = 0;
    window(100, 0, "R5");
    window(100, 5, "R6");
    window(3000, 3, "R5");
    window(20000, 0, "R5");
    window(1 << 20, 2, "R6");
    window(100, 0, "R5");
    window(100, 0, "R5");
    // R10: wideband switch while stored code is +3
    bwWide = 1'b1;
    for (int n = 0; n < 6; n++) step(1'b1, 3000 + n, 500, "R10");
    window(100, 0, "R10");
    step(1'b0, 0, 0, "R8");
    step(1'b0, 0, 0, "R8");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule